// File: doc/BRIEF.md
# SD Card Command Line Engine

This block drives the command half of an SD card bus. Software loads a 32-bit argument, then writes a command word that names the command index, the kind of answer expected and whether the card will signal busy afterwards. Setting the start flag in that word launches the sequence. The engine serialises a 48-bit command frame onto the bidirectional CMD line, one bit per SD clock-enable tick. It then releases the line and listens for the card's answer.

A short answer (48 bits) or a long answer (136 bits) is captured into four response words, and the CRC7 of short answers is checked. Missing answers and bad checksums are recorded in a status word whose flags software clears by writing ones. The start flag stays high for the whole command and drops by itself at the end. A failure flag next to it tells software whether the command succeeded.

For commands that leave the card busy, a separate busy-release input stands in for the data-line busy signal. The engine holds the command open until that input goes high.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset the command word, argument and status read as zero, the answer-wait limit reads 64, and CMD output enable is low.
- R2: A launched command drives 48 bits MSB first, one bit per tick, in this order: a 0, a 1, the 6-bit index, the 32-bit argument, the CRC7 (polynomial x^7+x^3+1, register starting at zero) over the preceding 40 bits, and a closing 1. The first bit appears when output enable rises.
- R3: Command word bit 15 (start) stays 1 from the launching write until the command ends, then clears by itself. Bit 14 (failed) reads 1 after an unsuccessful end and 0 after a successful one.
- R4: With command bit 10 (no answer) set, the command ends right after the frame. No answer is captured and the response words keep their previous values.
- R5: Without bits 10 or 9, a 48-bit answer is captured and its 32 payload bits (answer bits 39:8) are placed in response word 0.
- R6: With bit 9 (long answer) set, a 136-bit answer is captured. Its 128 bits after the first 8 land with bits 31:0 in response word 0 and bits 127:96 in response word 3, and no CRC check is made.
- R7: A short answer whose CRC7 over answer bits 47:8 differs from answer bits 7:1 sets status bit 4 and the failed flag. This check is skipped for command indexes 1 and 41.
- R8: If no start bit (0) arrives within the limit held in word 2 (address 0x08), counted in ticks after the frame, status bit 6 and the failed flag are set. A start bit on exactly the limit-th tick is accepted.
- R9: With bit 11 (busy wait) on a short answer, the command stays open after capture until busy_release is high. The engine then sets status bit 10 and ends.
- R10: Writing ones to the status word (word 8, address 0x20) clears those bits, and writing 0xFFFF clears all of them. Bits 3, 5 and 7 always read zero.
- R11: A write to the command word while bit 15 is set is ignored: it neither changes the stored command nor starts a frame.
- R12: Word indexes are: command 0, argument 1, wait limit 2, response words 4 to 7, status 8. The argument and the limit read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word index of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| sd_tick | input | 1 | SD clock enable, one bit per high cycle |
| cmd_out | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable |
| cmd_in | input | 1 | CMD line input value |
| busy_release | input | 1 | High when the card has left busy |

## Verification
The bound checker watches, on every cycle:
- that output enable is only active while a command is open;
- that the first driven bit is the 0 start bit;
- that a command write during an open command leaves the stored command untouched;
- that a wait timeout leaves the timeout flag and the failed flag set with the command closed;
- that the busy flag only rises after busy_release was high;
- that a write of one clears the CRC flag.

The frame contents bit by bit, the CRC7 values, the placement of short and long answers in the response words, and the exact boundary of the wait limit can only be shown by the bench's scenarios, where a card model answers with chosen delays and chosen checksums.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;
    localparam int IDX_W      = 6;
    localparam int CRC_W      = 7;
    localparam int FRAME_W    = 48;
    localparam int LONG_W     = 136;
    localparam int CONTENT_W  = 128;
    localparam int RSP_WORDS  = CONTENT_W / DATA_W;
    localparam int CNT_W      = $clog2(LONG_W + 1);
    localparam int TMO_W      = 16;
    localparam int STAT_W     = 16;
    localparam int MSG_W      = FRAME_W - CRC_W - 1;

    localparam logic [ADDR_W-1:0] REG_CMD  = 4'd0;
    localparam logic [ADDR_W-1:0] REG_ARG  = 4'd1;
    localparam logic [ADDR_W-1:0] REG_TMO  = 4'd2;
    localparam logic [ADDR_W-1:0] REG_RSP0 = 4'd4;
    localparam logic [ADDR_W-1:0] REG_RSP3 = 4'd7;
    localparam logic [ADDR_W-1:0] REG_STAT = 4'd8;

    localparam logic [TMO_W-1:0] TMO_RESET = 16'd64;

    localparam int CB_GO    = 15;
    localparam int CB_FAIL  = 14;
    localparam int CB_BUSY  = 11;
    localparam int CB_NORSP = 10;
    localparam int CB_LONG  = 9;
    localparam int CB_WR    = 7;
    localparam int CB_RD    = 6;

    localparam int ST_CRC7 = 4;
    localparam int ST_CTMO = 6;
    localparam int ST_BUSY = 10;
    localparam logic [STAT_W-1:0] ST_MASK =
        STAT_W'((1 << ST_CRC7) | (1 << ST_CTMO) | (1 << ST_BUSY));

    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_W - 1);

    typedef enum logic [1:0] {RSP_NONE, RSP_SHORT, RSP_LONG} rsp_kind_e;
    typedef enum logic [1:0] {ENG_IDLE, ENG_TX, ENG_RX, ENG_BUSY} eng_state_e;

    typedef struct packed {
        logic             busy_wait;
        logic             no_rsp;
        logic             long_rsp;
        logic             dir_wr;
        logic             dir_rd;
        logic [IDX_W-1:0] index;
    } cmd_cfg_t;

    function automatic cmd_cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
        cmd_cfg_t c;
        c.busy_wait = w[CB_BUSY];
        c.no_rsp    = w[CB_NORSP];
        c.long_rsp  = w[CB_LONG];
        c.dir_wr    = w[CB_WR];
        c.dir_rd    = w[CB_RD];
        c.index     = w[IDX_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input cmd_cfg_t c,
                                                      input logic go,
                                                      input logic fail);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[CB_GO]       = go;
        w[CB_FAIL]     = fail;
        w[CB_BUSY]     = c.busy_wait;
        w[CB_NORSP]    = c.no_rsp;
        w[CB_LONG]     = c.long_rsp;
        w[CB_WR]       = c.dir_wr;
        w[CB_RD]       = c.dir_rd;
        w[IDX_W-1:0]   = c.index;
        return w;
    endfunction

    function automatic rsp_kind_e kind_of(input cmd_cfg_t c);
        if (c.no_rsp)
            return RSP_NONE;
        else if (c.long_rsp)
            return RSP_LONG;
        return RSP_SHORT;
    endfunction

    function automatic logic [CRC_W-1:0] crc7_of(input logic [MSG_W-1:0] m);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = '0;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ m[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb)
                r = r ^ 7'h09;
        end
        return r;
    endfunction

    function automatic logic crc_checked(input logic [IDX_W-1:0] idx);
        return (idx != 6'd1) && (idx != 6'd41);
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input logic [IDX_W-1:0] idx,
                                                       input logic [DATA_W-1:0] arg);
        logic [MSG_W-1:0] m;
        m = {2'b01, idx, arg};
        return {m, crc7_of(m), 1'b1};
    endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
    import sdcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               line_out,
    output logic               line_oe,
    output logic               done
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q  <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                shreg_q  <= frame;
                cnt_q    <= '0;
                active_q <= 1'b1;
            end else if (active_q && tick) begin
                if (cnt_q == LAST_BIT) begin
                    active_q <= 1'b0;
                    done     <= 1'b1;
                end else begin
                    shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                    cnt_q   <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign line_out = active_q ? shreg_q[FRAME_W-1] : 1'b1;
    assign line_oe  = active_q;
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
    import sdcmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 start,
    input  logic                 long_mode,
    input  logic [TMO_W-1:0]     limit,
    input  logic                 line_in,
    output logic                 done,
    output logic                 timed_out,
    output logic [CONTENT_W-1:0] data
);
    typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_CAPT} rx_state_e;

    rx_state_e          state_q;
    logic [TMO_W-1:0]   wait_q;
    logic [CNT_W-1:0]   bit_q;
    logic [CNT_W-1:0]   last_bit;

    assign last_bit = long_mode ? LAST_LONG : LAST_SHORT;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RX_IDLE;
            wait_q    <= '0;
            bit_q     <= '0;
            data      <= '0;
            done      <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            done      <= 1'b0;
            timed_out <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (start) begin
                        state_q <= RX_HUNT;
                        wait_q  <= '0;
                        data    <= '0;
                    end
                end
                RX_HUNT: begin
                    if (tick) begin
                        if (!line_in) begin
                            state_q <= RX_CAPT;
                            bit_q   <= CNT_W'(1);
                            data    <= {data[CONTENT_W-2:0], line_in};
                        end else if (wait_q == limit - TMO_W'(1)) begin
                            state_q   <= RX_IDLE;
                            done      <= 1'b1;
                            timed_out <= 1'b1;
                        end else begin
                            wait_q <= wait_q + 1'b1;
                        end
                    end
                end
                RX_CAPT: begin
                    if (tick) begin
                        data  <= {data[CONTENT_W-2:0], line_in};
                        bit_q <= bit_q + 1'b1;
                        if (bit_q == last_bit) begin
                            state_q <= RX_IDLE;
                            done    <= 1'b1;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_status.sv
module sdcmd_status
    import sdcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_en,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic [STAT_W-1:0] set_vec,
    output logic [STAT_W-1:0] stat
);
    always_ff @(posedge clk) begin
        if (rst)
            stat <= '0;
        else
            stat <= ((stat & ~(clr_en ? clr_mask : '0)) | set_vec) & ST_MASK;
    end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sd_tick,
    output logic              cmd_out,
    output logic              cmd_oe,
    input  logic              cmd_in,
    input  logic              busy_release
);
    eng_state_e   state_q, state_d;
    cmd_cfg_t     cfg_q;
    logic         go_q, failed_q;
    logic [DATA_W-1:0] arg_q;
    logic [TMO_W-1:0]  tmo_q;
    logic [RSP_WORDS-1:0][DATA_W-1:0] rsp_q;

    logic cmd_wr, cmd_accept, tx_start, tx_done;
    logic rx_start, rx_done, rx_tmo;
    logic [CONTENT_W-1:0] rx_data;
    logic finish, fail_now, load_short, load_long;
    logic set_crc, set_tmo, set_busy, crc_bad;
    logic [STAT_W-1:0] stat_q, set_vec;
    rsp_kind_e kind;

    assign cmd_wr     = reg_wr_en && (reg_addr == REG_CMD);
    assign cmd_accept = cmd_wr && !go_q;
    assign tx_start   = cmd_accept && reg_wdata[CB_GO];
    assign kind       = kind_of(cfg_q);
    assign crc_bad    = crc_checked(cfg_q.index) &&
                        (crc7_of(rx_data[FRAME_W-1:CRC_W+1]) != rx_data[CRC_W:1]);

    sdcmd_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (sd_tick),
        .start    (tx_start),
        .frame    (build_frame(cfg_from_word(reg_wdata).index, arg_q)),
        .line_out (cmd_out),
        .line_oe  (cmd_oe),
        .done     (tx_done)
    );

    sdcmd_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .tick      (sd_tick),
        .start     (rx_start),
        .long_mode (kind == RSP_LONG),
        .limit     (tmo_q),
        .line_in   (cmd_in),
        .done      (rx_done),
        .timed_out (rx_tmo),
        .data      (rx_data)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[ST_CRC7] = set_crc;
        set_vec[ST_CTMO] = set_tmo;
        set_vec[ST_BUSY] = set_busy;
    end

    sdcmd_status u_status (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (reg_wr_en && (reg_addr == REG_STAT)),
        .clr_mask (reg_wdata[STAT_W-1:0]),
        .set_vec  (set_vec),
        .stat     (stat_q)
    );

    always_comb begin
        state_d    = state_q;
        finish     = 1'b0;
        fail_now   = 1'b0;
        rx_start   = 1'b0;
        load_short = 1'b0;
        load_long  = 1'b0;
        set_crc    = 1'b0;
        set_tmo    = 1'b0;
        set_busy   = 1'b0;
        unique case (state_q)
            ENG_IDLE: begin
                if (tx_start)
                    state_d = ENG_TX;
            end
            ENG_TX: begin
                if (tx_done) begin
                    if (kind == RSP_NONE) begin
                        finish = 1'b1;
                    end else begin
                        rx_start = 1'b1;
                        state_d  = ENG_RX;
                    end
                end
            end
            ENG_RX: begin
                if (rx_done) begin
                    if (rx_tmo) begin
                        set_tmo  = 1'b1;
                        fail_now = 1'b1;
                        finish   = 1'b1;
                    end else if (kind == RSP_LONG) begin
                        load_long = 1'b1;
                        finish    = 1'b1;
                    end else begin
                        load_short = 1'b1;
                        if (crc_bad) begin
                            set_crc  = 1'b1;
                            fail_now = 1'b1;
                            finish   = 1'b1;
                        end else if (cfg_q.busy_wait) begin
                            state_d = ENG_BUSY;
                        end else begin
                            finish = 1'b1;
                        end
                    end
                end
            end
            ENG_BUSY: begin
                if (busy_release) begin
                    set_busy = 1'b1;
                    finish   = 1'b1;
                end
            end
            default: state_d = ENG_IDLE;
        endcase
        if (finish)
            state_d = ENG_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ENG_IDLE;
            cfg_q    <= '0;
            go_q     <= 1'b0;
            failed_q <= 1'b0;
            arg_q    <= '0;
            tmo_q    <= TMO_RESET;
            rsp_q    <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_accept) begin
                cfg_q    <= cfg_from_word(reg_wdata);
                go_q     <= reg_wdata[CB_GO];
                failed_q <= 1'b0;
            end
            if (finish) begin
                go_q     <= 1'b0;
                failed_q <= fail_now;
            end
            if (reg_wr_en && (reg_addr == REG_ARG))
                arg_q <= reg_wdata;
            if (reg_wr_en && (reg_addr == REG_TMO))
                tmo_q <= reg_wdata[TMO_W-1:0];
            if (load_short)
                rsp_q[0] <= rx_data[FRAME_W-IDX_W-3:CRC_W+1];
            if (load_long) begin
                for (int i = 0; i < RSP_WORDS; i++)
                    rsp_q[i] <= rx_data[DATA_W*i +: DATA_W];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_CMD)
            reg_rdata = cfg_to_word(cfg_q, go_q, failed_q);
        else if (reg_addr == REG_ARG)
            reg_rdata = arg_q;
        else if (reg_addr == REG_TMO)
            reg_rdata = DATA_W'(tmo_q);
        else if (reg_addr == REG_STAT)
            reg_rdata = DATA_W'(stat_q);
        else if ((reg_addr >= REG_RSP0) && (reg_addr <= REG_RSP3))
            reg_rdata = rsp_q[reg_addr[1:0]];
    end
endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker
    import sdcmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              go_q,
    input logic              failed_q,
    input logic [10:0]       cfg_bits,
    input logic              cmd_oe,
    input logic              cmd_out,
    input logic              busy_release,
    input logic              rx_tmo_end,
    input logic              set_crc,
    input logic              crc_flag,
    input logic              tmo_flag,
    input logic              busy_flag
);
    assert_oe_open_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_oe |-> go_q);

    assert_start_bit_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_oe) |-> !cmd_out);

    assert_ignore_write_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == REG_CMD && go_q) |=> $stable(cfg_bits));

    assert_timeout_flags_R8: assert property (@(posedge clk) disable iff (rst)
        rx_tmo_end |=> (tmo_flag && failed_q && !go_q));

    assert_busy_after_release_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_flag) |-> $past(busy_release));

    assert_w1c_crc_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == REG_STAT && reg_wdata[ST_CRC7] && !set_crc)
            |=> !crc_flag);
endmodule

bind sdcmd_engine sdcmd_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .go_q         (go_q),
    .failed_q     (failed_q),
    .cfg_bits     (cfg_q),
    .cmd_oe       (cmd_oe),
    .cmd_out      (cmd_out),
    .busy_release (busy_release),
    .rx_tmo_end   (rx_done && rx_tmo),
    .set_crc      (set_crc),
    .crc_flag     (stat_q[4]),
    .tmo_flag     (stat_q[6]),
    .busy_flag    (stat_q[10])
);

// File: tb/sdcmd_engine_bench.sv
module sdcmd_engine_bench;
    import sdcmd_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sd_tick = 1'b0;
    logic        cmd_out, cmd_oe;
    logic        cmd_in = 1'b1;
    logic        busy_release = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit exp_q[$];

    sdcmd_engine u_sdcmd_engine (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_tick(sd_tick),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in),
        .busy_release(busy_release)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int ph;
        ph = 0;
        forever begin
            @(posedge clk);
            ph = (ph + 1) % 4;
            sd_tick <= (ph == 0);
        end
    end

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: compares every driven CMD bit against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (sd_tick && cmd_oe) begin
                if (exp_q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R11 unexpected CMD bit: got %b expected none", cmd_out);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    check("R2", "frame bit", {31'b0, cmd_out}, {31'b0, e});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R3 watchdog: got hung expected command end");
        finish_up();
    end

    function automatic logic [6:0] ref_crc(input logic [39:0] m);
        logic [6:0] r;
        r = '0;
        for (int k = 39; k >= 0; k--) begin
            logic top;
            top = r[6] ^ m[k];
            r = {r[5:0], 1'b0} ^ (top ? 7'b0001001 : 7'b0000000);
        end
        return r;
    endfunction

    function automatic logic [47:0] short_rsp(input logic [5:0] idx,
                                              input logic [31:0] pay,
                                              input bit corrupt);
        logic [39:0] m;
        m = {2'b00, idx, pay};
        return {m, ref_crc(m) ^ {6'b0, corrupt}, 1'b1};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!sd_tick);
        @(posedge clk);
    endtask

    task automatic send_bits(input logic [135:0] bits, input int n);
        for (int k = n - 1; k >= 0; k--) begin
            cmd_in <= bits[k];
            wait_tick();
        end
        cmd_in <= 1'b1;
    endtask

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                         input logic [31:0] flags);
        logic [47:0] f;
        logic [39:0] m;
        m = {2'b01, idx, arg};
        f = {m, ref_crc(m), 1'b1};
        for (int k = 47; k >= 0; k--) exp_q.push_back(f[k]);
        wr(REG_ARG, arg);
        wr(REG_CMD, 32'h8000 | flags | {26'b0, idx});
    endtask

    task automatic wait_frame_end();
        do @(negedge clk); while (!cmd_oe);
        do @(negedge clk); while (cmd_oe);
    endtask

    task automatic wait_idle(output logic [31:0] v);
        do rd(REG_CMD, v); while (v[15]);
    endtask

    initial begin
        logic [31:0] v;
        logic [127:0] body;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(REG_CMD, v);  check("R1", "command word", v, 32'h0);
        rd(REG_STAT, v); check("R1", "status", v, 32'h0);
        rd(REG_TMO, v);  check("R1", "wait limit", v, 32'd64);
        check("R1", "cmd_oe", {31'b0, cmd_oe}, 32'h0);
        // R12 register map readback
        wr(REG_ARG, 32'hA5A50F0F);
        rd(REG_ARG, v);  check("R12", "argument readback", v, 32'hA5A50F0F);

        // R5 short answer, good CRC
        issue(6'd17, 32'h12345678, 32'h0);
        wait_frame_end();
        rd(REG_CMD, v);  check("R3", "start held open", {31'b0, v[15]}, 32'h1);
        repeat (5) wait_tick();
        send_bits({88'b0, short_rsp(6'd17, 32'hCAFEF00D, 1'b0)}, 48);
        wait_idle(v);
        check("R3", "failed after success", {31'b0, v[14]}, 32'h0);
        rd(REG_RSP0, v); check("R5", "short payload", v, 32'hCAFEF00D);
        rd(REG_STAT, v); check("R5", "status after good", v, 32'h0);

        // R4 no-answer command leaves responses
        issue(6'd0, 32'h0, 32'h400);
        wait_frame_end();
        wait_idle(v);
        check("R4", "failed flag", {31'b0, v[14]}, 32'h0);
        rd(REG_RSP0, v); check("R4", "response kept", v, 32'hCAFEF00D);

        // R7 bad CRC
        issue(6'd13, 32'h00010000, 32'h0);
        wait_frame_end();
        repeat (3) wait_tick();
        send_bits({88'b0, short_rsp(6'd13, 32'h00000900, 1'b1)}, 48);
        wait_idle(v);
        check("R3", "failed after bad CRC", {31'b0, v[14]}, 32'h1);
        rd(REG_STAT, v); check("R7", "CRC flag", v, 32'h10);
        wr(REG_STAT, 32'hFFFF);
        rd(REG_STAT, v); check("R10", "clear all", v, 32'h0);

        // R7 exempt index 41
        issue(6'd41, 32'h40FF8000, 32'h0);
        wait_frame_end();
        repeat (2) wait_tick();
        send_bits({88'b0, short_rsp(6'd63, 32'h80FF8000, 1'b1)}, 48);
        wait_idle(v);
        check("R7", "index 41 not failed", {31'b0, v[14]}, 32'h0);
        rd(REG_STAT, v); check("R7", "index 41 status", v, 32'h0);
        rd(REG_RSP0, v); check("R5", "index 41 payload", v, 32'h80FF8000);

        // R6 long answer
        body = {32'h11112222, 32'h33334444, 32'h55556666, 32'h77778889};
        issue(6'd2, 32'h0, 32'h200);
        wait_frame_end();
        repeat (4) wait_tick();
        send_bits({2'b00, 6'h3F, body}, 136);
        wait_idle(v);
        check("R6", "failed flag", {31'b0, v[14]}, 32'h0);
        rd(4'd4, v); check("R6", "word 0", v, 32'h77778889);
        rd(4'd5, v); check("R6", "word 1", v, 32'h55556666);
        rd(4'd6, v); check("R6", "word 2", v, 32'h33334444);
        rd(4'd7, v); check("R6", "word 3", v, 32'h11112222);
        rd(REG_STAT, v); check("R6", "no CRC check", v, 32'h0);

        // R8 start bit on the 64th tick is accepted
        issue(6'd8, 32'h000001AA, 32'h0);
        wait_frame_end();
        repeat (63) wait_tick();
        send_bits({88'b0, short_rsp(6'd8, 32'h000001AA, 1'b0)}, 48);
        wait_idle(v);
        check("R8", "limit edge accepted", {31'b0, v[14]}, 32'h0);
        rd(REG_STAT, v); check("R8", "no timeout at edge", v, 32'h0);

        // R8 timeout
        issue(6'd8, 32'h000001AA, 32'h0);
        wait_frame_end();
        wait_idle(v);
        check("R8", "failed on timeout", {31'b0, v[14]}, 32'h1);
        rd(REG_STAT, v); check("R8", "timeout flag", v, 32'h40);

        // R10 partial clear and reserved bits
        issue(6'd13, 32'h0, 32'h0);
        wait_frame_end();
        repeat (2) wait_tick();
        send_bits({88'b0, short_rsp(6'd13, 32'h0, 1'b1)}, 48);
        wait_idle(v);
        rd(REG_STAT, v); check("R10", "two flags", v, 32'h50);
        wr(REG_STAT, 32'h0010);
        rd(REG_STAT, v); check("R10", "clear CRC only", v, 32'h40);
        wr(REG_STAT, 32'hFFFF);
        wr(REG_STAT, 32'h00A8);
        rd(REG_STAT, v); check("R10", "reserved bits zero", v, 32'h0);

        // R9 busy wait
        issue(6'd7, 32'h12340000, 32'h800);
        wait_frame_end();
        repeat (2) wait_tick();
        send_bits({88'b0, short_rsp(6'd7, 32'h00000700, 1'b0)}, 48);
        repeat (40) @(negedge clk);
        rd(REG_CMD, v);  check("R9", "held while busy", {31'b0, v[15]}, 32'h1);
        rd(REG_STAT, v); check("R9", "no flag while busy", v, 32'h0);
        @(negedge clk);
        busy_release = 1'b1;
        wait_idle(v);
        busy_release = 1'b0;
        rd(REG_STAT, v); check("R9", "busy flag", v, 32'h400);
        wr(REG_STAT, 32'hFFFF);

        // R11 command write during open command
        issue(6'd24, 32'hDEAD0000, 32'h400);
        do @(negedge clk); while (!cmd_oe);
        repeat (20) @(negedge clk);
        wr(REG_CMD, 32'h8405);
        wait_frame_end();
        wait_idle(v);
        check("R11", "index kept", {26'b0, v[5:0]}, 32'd24);
        repeat (80) @(negedge clk);
        check("R11", "no second frame", {31'b0, cmd_oe}, 32'h0);

        // R8 programmable limit
        wr(REG_TMO, 32'd10);
        rd(REG_TMO, v); check("R12", "limit readback", v, 32'd10);
        issue(6'd9, 32'h0, 32'h0);
        wait_frame_end();
        repeat (10) wait_tick();
        send_bits({88'b0, short_rsp(6'd9, 32'h0, 1'b0)}, 48);
        wait_idle(v);
        rd(REG_STAT, v); check("R8", "short limit timeout", v, 32'h40);
        wr(REG_STAT, 32'hFFFF);
        wr(REG_TMO, 32'd64);

        check("R2", "frames consumed", exp_q.size(), 32'd0);
        finish_up();
    end
endmodule